// File: doc/BRIEF.md
# Core Program Loader and Launcher

This block starts programs on a cluster of small cores, eight by default. A launch request either names one core or asks for any idle one; in the second case the lowest-numbered idle core is taken. The block then moves a fixed image of 512 words of 32 bits out of shared main memory into that core's private program RAM, one word for each access slot the shared-memory arbiter grants. Once the last word is in place, a 14-bit parameter captured with the request goes into the core's parameter register, and the core's run flag is raised.

The rise of the run flag tells the core to begin fetching at local address 0. The block keeps one run flag per core. The core can clear its own flag through a halt input, which makes that core idle again. A request for any core that finds every core running is refused with a one-cycle failure pulse, and no memory traffic follows. A request that names a core which is already running stops that core and then reloads it. While a copy is in progress the block is busy and ignores new requests.

Top module: `core_launcher`

## Requirements
- R1: After reset, busy_o, fail_o and mem_req_o are low, every core_run_o bit is 0, and no core RAM write enable is set.
- R2: When a request is accepted with any_i=1, the target is the lowest-numbered core whose run flag is 0. core_id_o shows that core from the cycle after acceptance.
- R3: When a request is accepted with any_i=0, the target is core_sel_i, whether or not that core is running. Its run flag is 0 from the cycle after acceptance until the release.
- R4: When a request is accepted with any_i=1 and every run flag is 1, fail_o is high for exactly the next cycle and busy_o stays low. No memory request, core RAM write or run-flag change follows.
- R5: A launch writes every local address 0..511 of the target core's RAM exactly once. Local address i receives the shared-memory word at src_addr_i+i, taken modulo 2^16. No other core's RAM is written.
- R6: Each granted cycle (mem_req_o and mem_gnt_i both high) copies exactly one word and then advances mem_addr_o by one. In a cycle without a grant, nothing is written and mem_addr_o holds.
- R7: param_i is captured when the request is accepted, and changes to it during the copy have no effect. At release, the captured value appears on the target's 14-bit slice core_param_o[k*14 +: 14].
- R8: The target's run flag rises, and busy_o falls, on the clock edge that stores the 512th word. That rise is the core's signal to start at local address 0.
- R9: busy_o is high from the cycle after acceptance until the release. Requests that arrive while busy_o is high are ignored: the target, the parameter and the other cores' run flags do not change.
- R10: A pulse on core_halt_i[k] clears the run flag of core k, and core k can then be chosen by an any-core request. A release to the same core in the same cycle takes priority over the halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Launch request, sampled when not busy |
| any_i | input | 1 | 1: lowest idle core, 0: core_sel_i |
| core_sel_i | input | 3 | Named target core |
| src_addr_i | input | 16 | Word address of image start in shared memory |
| param_i | input | 14 | Parameter passed to the launched core |
| busy_o | output | 1 | Copy in progress |
| core_id_o | output | 3 | Core chosen by the last accepted launch |
| fail_o | output | 1 | One-cycle pulse: no idle core |
| mem_req_o | output | 1 | Shared-memory read request |
| mem_addr_o | output | 16 | Shared-memory word address |
| mem_gnt_i | input | 1 | Access slot granted this cycle |
| mem_rdata_i | input | 32 | Read data, valid in the granted cycle |
| cram_we_o | output | 8 | Per-core local RAM write enable |
| cram_addr_o | output | 9 | Local RAM word address |
| cram_wdata_o | output | 32 | Local RAM write data |
| core_run_o | output | 8 | Per-core run flag; a rise means start at address 0 |
| core_param_o | output | 112 | Per-core 14-bit parameter registers |
| core_halt_i | input | 8 | Per-core self-halt |

## Verification
The assertions hold on every cycle the following properties:
- at most one core RAM is written per cycle, and only in a granted cycle;
- mem_addr_o steps on a grant and holds without one;
- no core is written while it runs;
- core_id_o is stable during a copy;
- a failure pulse never coincides with busy or a memory request;
- a core is always running at the moment busy_o falls.

Other behaviour can only be shown by the bench's scenarios:
- the choice of the lowest idle core;
- the reload of a running core;
- that the copied contents match, address for address;
- that the parameter is captured at acceptance;
- that requests made while busy are ignored;
- that a halted core becomes selectable again.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_COPY = 1'b1
  } lc_state_e;
endpackage

// File: rtl/lc_pick.sv
// Lowest-index set bit finder.
module lc_pick #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  idle_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (idle_i[k]) begin
        found_o = 1'b1;
        idx_o   = IW'(k);
      end
    end
  end
endmodule

// File: rtl/lc_copy_ctr.sv
// Word counter for one image copy.
module lc_copy_ctr #(
  parameter int WORDS = 512,
  localparam int LW = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  output logic [LW-1:0] cnt_o,
  output logic          last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (step_i) cnt_o <= cnt_o + 1'b1;
  end

  assign last_o = (cnt_o == LW'(WORDS - 1));
endmodule

// File: rtl/lc_core_slot.sv
// Run flag and parameter register of one core.
module lc_core_slot #(
  parameter int PW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          halt_i,
  input  logic [PW-1:0] param_i,
  output logic          run_o,
  output logic [PW-1:0] param_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o   <= 1'b0;
      param_o <= '0;
    end else if (start_i) begin
      run_o   <= 1'b1;
      param_o <= param_i;
    end else if (stop_i || halt_i) begin
      run_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/core_launcher.sv
module core_launcher #(
  parameter int N_CORES   = 8,
  parameter int IMG_WORDS = 512,
  parameter int DW        = 32,
  parameter int AW        = 16,
  parameter int PW        = 14,
  localparam int IW = $clog2(N_CORES),
  localparam int LW = $clog2(IMG_WORDS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  any_i,
  input  logic [IW-1:0]         core_sel_i,
  input  logic [AW-1:0]         src_addr_i,
  input  logic [PW-1:0]         param_i,
  output logic                  busy_o,
  output logic [IW-1:0]         core_id_o,
  output logic                  fail_o,
  output logic                  mem_req_o,
  output logic [AW-1:0]         mem_addr_o,
  input  logic                  mem_gnt_i,
  input  logic [DW-1:0]         mem_rdata_i,
  output logic [N_CORES-1:0]    cram_we_o,
  output logic [LW-1:0]         cram_addr_o,
  output logic [DW-1:0]         cram_wdata_o,
  output logic [N_CORES-1:0]    core_run_o,
  output logic [N_CORES*PW-1:0] core_param_o,
  input  logic [N_CORES-1:0]    core_halt_i
);
  import lc_pkg::*;

  lc_state_e     state_q;
  logic [AW-1:0] src_q;
  logic [PW-1:0] prm_q;
  logic [IW-1:0] tgt_q;
  logic          fail_q;

  logic          found;
  logic [IW-1:0] pick_idx;
  logic [IW-1:0] tgt_d;
  logic          accept, launch_ok, step, last, finish;
  logic [LW-1:0] cnt;

  lc_pick #(.N(N_CORES)) u_pick (
    .idle_i  (~core_run_o),
    .found_o (found),
    .idx_o   (pick_idx)
  );

  assign accept    = (state_q == ST_IDLE) && req_i;
  assign tgt_d     = any_i ? pick_idx : core_sel_i;
  assign launch_ok = accept && (!any_i || found);
  assign step      = (state_q == ST_COPY) && mem_gnt_i;
  assign finish    = step && last;

  lc_copy_ctr #(.WORDS(IMG_WORDS)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (launch_ok),
    .step_i (step),
    .cnt_o  (cnt),
    .last_o (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      prm_q   <= '0;
      tgt_q   <= '0;
      fail_q  <= 1'b0;
    end else begin
      fail_q <= accept && any_i && !found;
      if (launch_ok) begin
        state_q <= ST_COPY;
        src_q   <= src_addr_i;
        prm_q   <= param_i;
        tgt_q   <= tgt_d;
      end else if (finish) begin
        state_q <= ST_IDLE;
      end
    end
  end

  for (genvar k = 0; k < N_CORES; k++) begin : g_slot
    lc_core_slot #(.PW(PW)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (finish && (tgt_q == IW'(k))),
      .stop_i  (launch_ok && (tgt_d == IW'(k))),
      .halt_i  (core_halt_i[k]),
      .param_i (prm_q),
      .run_o   (core_run_o[k]),
      .param_o (core_param_o[k*PW +: PW])
    );
    assign cram_we_o[k] = step && (tgt_q == IW'(k));
  end

  assign busy_o       = (state_q == ST_COPY);
  assign core_id_o    = tgt_q;
  assign fail_o       = fail_q;
  assign mem_req_o    = (state_q == ST_COPY);
  assign mem_addr_o   = src_q + AW'(cnt);
  assign cram_addr_o  = cnt;
  assign cram_wdata_o = mem_rdata_i;
endmodule

// File: rtl/core_launcher_chk.sv
module core_launcher_chk #(
  parameter int N_CORES   = 8,
  parameter int IMG_WORDS = 512,
  parameter int AW        = 16,
  localparam int IW = $clog2(N_CORES),
  localparam int LW = $clog2(IMG_WORDS)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               busy_o,
  input logic [IW-1:0]      core_id_o,
  input logic               fail_o,
  input logic               mem_req_o,
  input logic [AW-1:0]      mem_addr_o,
  input logic               mem_gnt_i,
  input logic [N_CORES-1:0] cram_we_o,
  input logic [LW-1:0]      cram_addr_o,
  input logic [N_CORES-1:0] core_run_o
);
  // R5
  one_ram_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cram_we_o));

  // R6
  write_needs_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cram_we_o != '0) |-> (mem_req_o && mem_gnt_i));

  // R6
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_gnt_i && cram_addr_o != LW'(IMG_WORDS - 1))
      |=> (mem_addr_o == $past(mem_addr_o) + 1'b1));

  // R6
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> $stable(mem_addr_o));

  // R3
  no_write_running_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cram_we_o & core_run_o) == '0);

  // R9
  target_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(core_id_o));

  // R4
  fail_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (!busy_o && !mem_req_o));

  // R8
  release_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> core_run_o[core_id_o]);
endmodule

bind core_launcher core_launcher_chk #(
  .N_CORES(N_CORES), .IMG_WORDS(IMG_WORDS), .AW(AW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .core_id_o(core_id_o),
  .fail_o(fail_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
  .mem_gnt_i(mem_gnt_i), .cram_we_o(cram_we_o), .cram_addr_o(cram_addr_o),
  .core_run_o(core_run_o)
);

// File: tb/core_launcher_tb.sv
`timescale 1ns/1ps
module core_launcher_tb;
  localparam int N  = 8;
  localparam int WD = 512;
  localparam int AW = 16;
  localparam int PW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, any = 1'b0;
  logic [2:0]    sel = '0;
  logic [AW-1:0] src = '0;
  logic [PW-1:0] prm = '0;
  logic [N-1:0]  halt = '0;
  logic          gnt_en = 1'b1;
  int            gap = 1;
  int            gcnt = 0;

  logic          busy, fail, mreq, gnt;
  logic [2:0]    cid;
  logic [AW-1:0] maddr;
  logic [31:0]   rdata, wdata;
  logic [N-1:0]  we, run;
  logic [8:0]    waddr;
  logic [N*PW-1:0] cparam;

  int n_chk = 0, n_bad = 0;
  int wr_tot = 0, mreq_tot = 0;
  int wr_core [N];
  logic [31:0] ram [N][WD];

  always #4 clk = ~clk;

  function automatic logic [31:0] mf(input logic [AW-1:0] a);
    return {a, ~a};
  endfunction

  assign rdata = mf(maddr);
  assign gnt   = gnt_en && ((gcnt % gap) == 0);

  always @(posedge clk) begin
    gcnt <= gcnt + 1;
    if (rst_n) begin
      if (mreq) mreq_tot <= mreq_tot + 1;
      if (we != '0) wr_tot <= wr_tot + 1;
      for (int c = 0; c < N; c++)
        if (we[c]) begin
          ram[c][waddr] <= wdata;
          wr_core[c] <= wr_core[c] + 1;
        end
    end
  end

  core_launcher u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .any_i(any), .core_sel_i(sel),
    .src_addr_i(src), .param_i(prm), .busy_o(busy), .core_id_o(cid),
    .fail_o(fail), .mem_req_o(mreq), .mem_addr_o(maddr), .mem_gnt_i(gnt),
    .mem_rdata_i(rdata), .cram_we_o(we), .cram_addr_o(waddr),
    .cram_wdata_o(wdata), .core_run_o(run), .core_param_o(cparam),
    .core_halt_i(halt)
  );

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  typedef struct packed {
    logic          any;
    logic [2:0]    sel;
    logic [AW-1:0] src;
    logic [PW-1:0] prm;
    logic [2:0]    core;
    logic          fl;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{1'b1, 3'd0, 16'h0100, 14'h1234, 3'd0, 1'b0},
    '{1'b1, 3'd0, 16'h0800, 14'h0001, 3'd1, 1'b0},
    '{1'b0, 3'd5, 16'h2000, 14'h2AAA, 3'd5, 1'b0},
    '{1'b1, 3'd7, 16'hFF00, 14'h1555, 3'd2, 1'b0},
    '{1'b0, 3'd1, 16'h3000, 14'h3FFF, 3'd1, 1'b0},
    '{1'b1, 3'd0, 16'h4000, 14'h0003, 3'd3, 1'b0},
    '{1'b1, 3'd0, 16'h5000, 14'h0004, 3'd4, 1'b0},
    '{1'b1, 3'd0, 16'h6000, 14'h0006, 3'd6, 1'b0},
    '{1'b1, 3'd0, 16'h7000, 14'h0007, 3'd7, 1'b0},
    '{1'b1, 3'd0, 16'h8000, 14'h0008, 3'd0, 1'b1}
  };

  int base_wr, base_core, base_mreq;
  logic [N-1:0] run_before;

  // Drive a request for one cycle, then scramble param_i (R7).
  task automatic start(input logic a, input logic [2:0] s, input logic [AW-1:0] sa,
                       input logic [PW-1:0] p);
    @(negedge clk);
    req = 1'b1; any = a; sel = s; src = sa; prm = p;
    @(negedge clk);
    req = 1'b0; prm = ~p; src = ~sa;
  endtask

  task automatic finish_launch(input logic [2:0] c, input logic [AW-1:0] sa,
                               input logic [PW-1:0] p);
    int bad = 0;
    int cyc = 0;
    chk("R9 busy after accept", busy, 1'b1);
    chk("R2/R3 core id", cid, c);
    chk("R3 target stopped", run[c], 1'b0);
    while (busy && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk("R8 run at release", run[c], 1'b1);
    chk("R7 param", cparam[c*PW +: PW], p);
    chk("R5 words to target", wr_core[c] - base_core, WD);
    chk("R6 one write per grant", wr_tot - base_wr, WD);
    for (int i = 0; i < WD; i++)
      if (ram[c][i] !== mf(sa + AW'(i))) bad++;
    chk("R5 image contents", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < N; c++) wr_core[c] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 1'b0);
    chk("R1 fail", fail, 1'b0);
    chk("R1 mem_req", mreq, 1'b0);
    chk("R1 run", run, '0);
    chk("R1 we", we, '0);
    rst_n = 1'b1;

    for (int v = 0; v < 10; v++) begin
      gap = (v % 2 == 0) ? 1 : 4;
      base_wr = wr_tot; base_core = wr_core[VEC[v].core];
      base_mreq = mreq_tot; run_before = run;
      start(VEC[v].any, VEC[v].sel, VEC[v].src, VEC[v].prm);
      if (VEC[v].fl) begin
        chk("R4 fail pulse", fail, 1'b1);
        chk("R4 not busy", busy, 1'b0);
        @(negedge clk);
        chk("R4 fail one cycle", fail, 1'b0);
        repeat (4) @(negedge clk);
        chk("R4 no mem req", mreq_tot - base_mreq, 0);
        chk("R4 no writes", wr_tot - base_wr, 0);
        chk("R4 run unchanged", run, run_before);
      end else begin
        finish_launch(VEC[v].core, VEC[v].src, VEC[v].prm);
      end
    end

    // R10 halt makes core 4 selectable again
    @(negedge clk); halt = 8'h10;
    @(negedge clk); halt = '0;
    chk("R10 halted", run[4], 1'b0);
    base_wr = wr_tot; base_core = wr_core[4];
    start(1'b1, 3'd0, 16'h9000, 14'h0444);
    finish_launch(3'd4, 16'h9000, 14'h0444);

    // R6 stall and R9 ignored request during reload of core 2
    @(negedge clk); halt = 8'h40;
    @(negedge clk); halt = '0;
    gnt_en = 1'b0; gap = 2;
    base_wr = wr_tot; base_core = wr_core[2];
    start(1'b0, 3'd2, 16'hA000, 14'h0222);
    repeat (10) @(negedge clk);
    chk("R6 addr held without grant", maddr, 16'hA000);
    chk("R6 no write without grant", wr_tot - base_wr, 0);
    req = 1'b1; any = 1'b1; prm = 14'h0999;
    @(negedge clk);
    req = 1'b0;
    chk("R9 ignored request", cid, 3'd2);
    gnt_en = 1'b1;
    finish_launch(3'd2, 16'hA000, 14'h0222);
    chk("R9 core 6 untouched", run[6], 1'b0);

    // R1 reset during a copy
    start(1'b0, 3'd3, 16'hB000, 14'h0333);
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", busy, 1'b0);
    chk("R1 run after reset", run, '0);
    chk("R1 mem_req after reset", mreq, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule